// File: doc/BRIEF.md
# Slow-clock counter with match interrupt

This block keeps time from a slow reference clock (nominally 32.768 kHz) that runs alongside a fast bus clock. A 32-bit count advances in the slow domain. The rate is divided by a programmable trim value. A compare value raises a sticky interrupt when the count reaches it. Software sees four word registers on a simple bus: control/status, trim, count and match. Addresses are 0, 1, 2 and 3, and `bus_rdata` is combinational from `bus_addr`. A write occurs on any clock edge where `bus_sel` and `bus_wr` are both high.

Writes to trim, count and match are not applied at once. Each is captured into a bus-side holding register and handed to the slow domain through a toggle handshake. Each of the three registers has its own transfer state machine with two states:
- `CH_IDLE`: the channel can accept a write.
- `CH_BUSY`: the channel is waiting for the slow side to acknowledge.

The transition `CH_IDLE`→`CH_BUSY` happens on an accepted write. The transition `CH_BUSY`→`CH_IDLE` happens once the synchronised acknowledge toggle equals the request toggle. While a channel is in `CH_BUSY`, its pending bit reads 1. Software schedules an event by reading the count, adding a delta and writing the sum to match. Because of the crossing time, deltas below about 9 slow ticks are not dependable.

Reads of the count come from a snapshot register. The slow domain refreshes it through a second, continuously cycling handshake, so a read always returns one coherent 32-bit value.

Top module: `slow_tick_timer`

## Requirements
- R1: After reset, control/status (address 0) reads 0 and `irq` is low while the slow clock has not yet toggled.
- R2: With enable (control bit 0) set, the count rises by one every TRIM+1 slow-clock rising edges. With enable clear, the count holds its value.
- R3: The count wraps from 0xFFFFFFFF to 0x00000000.
- R4: A write to address 2 loads the count, whether or not enable is set. Once the load has taken effect, address 2 reads back exactly the loaded 32-bit value.
- R5: Control bits 2, 3 and 4 are the pending flags for trim, count and match. Each reads 1 in the cycle after its register is written, and returns to 0 on its own once the value has been applied in the slow domain.
- R6: A write to trim, count or match while that register's pending flag is set is ignored. The earlier value remains the one applied and read back.
- R7: Control bit 5 (the match flag, mirrored on `irq`) sets when the count becomes equal to the match value, and is 0 before that point.
- R8: Writing 1 to control bit 5 clears the match flag and `irq`. Writing 0 to it has no effect.
- R9: Control bit 1 sets after the first slow-clock edges and then stays set, even if the slow clock stops.
- R10: Address 1 reads the accepted trim value (low TRIM_W bits). Address 3 reads the accepted match value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Slow reference clock |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address: 0 control, 1 trim, 2 count, 3 match |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Sticky match interrupt |

## Verification
A transfer channel stuck in `CH_BUSY`, or one that leaves it too early, shows up within a few slow periods. It appears as a pending bit that never clears, or as a readback or count that does not match the last accepted write. A wrong prescaler or enable path makes the count read after a fixed window of slow edges differ from floor(edges/(TRIM+1)). This is visible as soon as the snapshot refreshes. A lost or spurious match event appears on `irq` within a few bus cycles of the slow edge where the count reaches the match value.

// File: rtl/slow_tick_pkg.sv
package slow_tick_pkg;
    typedef enum logic {CH_IDLE, CH_BUSY} chan_state_e;

    localparam int NCHAN = 3;

    // register addresses; transfer channel i sits at address i+1
    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_TRIM  = 2'd1;
    localparam logic [1:0] A_COUNT = 2'd2;
    localparam logic [1:0] A_MATCH = 2'd3;

    localparam int CH_TRIM  = 0;
    localparam int CH_COUNT = 1;
    localparam int CH_MATCH = 2;

    // control/status bit positions
    localparam int B_EN   = 0;
    localparam int B_DET  = 1;
    localparam int B_PEND = 2;
    localparam int B_FLAG = 5;
endpackage

// File: rtl/stt_sync.sv
module stt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = STAGES * W;

    logic [CW-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CW-W-1:0], d};
    end

    assign q = chain[CW-1 -: W];
endmodule

// File: rtl/stt_wr_chan.sv
module stt_wr_chan
    import slow_tick_pkg::*;
#(
    parameter int W      = 32,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] hold,
    output logic         busy,
    output logic [W-1:0] s_val,
    output logic         s_load
);
    chan_state_e state, state_nx;
    logic req_t, ack_t, req_s, ack_b;

    // bus side: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (wr_en)          state_nx = CH_BUSY;
            CH_BUSY: if (ack_b == req_t) state_nx = CH_IDLE;
        endcase
    end

    // bus side: outputs of the transfer machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= '0;
            req_t <= 1'b0;
        end else if (state == CH_IDLE && wr_en) begin
            hold  <= wdata;
            req_t <= ~req_t;
        end
    end

    assign busy = (state == CH_BUSY);

    stt_sync #(.W(1), .STAGES(SYNC_N)) u_req_sync (
        .clk(sclk), .rst_n(rst_n), .d(req_t), .q(req_s)
    );

    // slow side: apply held value once per request toggle
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            s_val  <= '0;
            ack_t  <= 1'b0;
            s_load <= 1'b0;
        end else begin
            s_load <= (req_s != ack_t);
            if (req_s != ack_t) begin
                s_val <= hold;
                ack_t <= req_s;
            end
        end
    end

    stt_sync #(.W(1), .STAGES(SYNC_N)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_t), .q(ack_b)
    );
endmodule

// File: rtl/stt_snap.sv
module stt_snap #(
    parameter int W      = 32,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic [W-1:0] s_cnt,
    output logic [W-1:0] rd_cnt
);
    logic         req_t, req_s, ack_t, ack_b;
    logic [W-1:0] snap;

    stt_sync #(.W(1), .STAGES(SYNC_N)) u_req_sync (
        .clk(sclk), .rst_n(rst_n), .d(req_t), .q(req_s)
    );

    // slow side captures only when asked; snap then stays still until the next request
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            snap  <= '0;
            ack_t <= 1'b0;
        end else if (req_s != ack_t) begin
            snap  <= s_cnt;
            ack_t <= req_s;
        end
    end

    stt_sync #(.W(1), .STAGES(SYNC_N)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_t), .q(ack_b)
    );

    // bus side copies a settled snapshot and immediately asks for the next one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            req_t  <= 1'b1;
        end else if (ack_b == req_t) begin
            rd_cnt <= snap;
            req_t  <= ~req_t;
        end
    end
endmodule

// File: rtl/stt_core.sv
module stt_core #(
    parameter int CNT_W = 32
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] trim,
    input  logic             trim_ld,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ld,
    input  logic [CNT_W-1:0] match_val,
    input  logic             match_ld,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_t,
    output logic             seen
);
    logic [CNT_W-1:0] pre;
    logic             hit_now, hit_prev;

    assign hit_now = (cnt == match_val);

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            pre      <= '0;
            cnt      <= '0;
            hit_prev <= 1'b1;
            hit_t    <= 1'b0;
            seen     <= 1'b0;
        end else begin
            seen <= 1'b1;
            if (cnt_ld) begin
                cnt <= cnt_val;
                pre <= '0;
            end else if (trim_ld) begin
                pre <= '0;
            end else if (en) begin
                if (pre >= trim) begin
                    pre <= '0;
                    cnt <= cnt + 1'b1;
                end else begin
                    pre <= pre + 1'b1;
                end
            end
            hit_prev <= match_ld ? 1'b0 : hit_now;
            if (hit_now && !hit_prev) hit_t <= ~hit_t;
        end
    end
endmodule

// File: rtl/slow_tick_timer.sv
module slow_tick_timer
    import slow_tick_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam logic [CNT_W-1:0] TRIM_MASK = CNT_W'((64'd1 << TRIM_W) - 64'd1);

    logic                        wr;
    logic [NCHAN-1:0]            wr_stb, busy, s_load;
    logic [NCHAN-1:0][CNT_W-1:0] wdat, hold, s_val;
    logic                        en_q, en_s, det_q, seen, seen_b;
    logic                        hit_t, hit_b, hit_d, m_evt, flag, w1c;
    logic [CNT_W-1:0]            s_cnt, rd_cnt;

    assign wr = bus_sel && bus_wr;

    generate
        for (genvar i = 0; i < NCHAN; i++) begin : g_chan
            assign wr_stb[i] = wr && (bus_addr == 2'(i + 1));
            if (i == CH_TRIM) begin : g_trim
                assign wdat[i] = bus_wdata & TRIM_MASK;
            end else begin : g_full
                assign wdat[i] = bus_wdata;
            end
            stt_wr_chan #(.W(CNT_W), .SYNC_N(SYNC_N)) u_chan (
                .clk(clk), .rst_n(rst_n), .sclk(sclk),
                .wr_en(wr_stb[i]), .wdata(wdat[i]),
                .hold(hold[i]), .busy(busy[i]),
                .s_val(s_val[i]), .s_load(s_load[i])
            );
        end
    endgenerate

    stt_sync #(.W(1), .STAGES(SYNC_N)) u_en_sync (
        .clk(sclk), .rst_n(rst_n), .d(en_q), .q(en_s)
    );

    stt_core #(.CNT_W(CNT_W)) u_core (
        .sclk(sclk), .rst_n(rst_n), .en(en_s),
        .trim(s_val[CH_TRIM]),   .trim_ld(s_load[CH_TRIM]),
        .cnt_val(s_val[CH_COUNT]), .cnt_ld(s_load[CH_COUNT]),
        .match_val(s_val[CH_MATCH]), .match_ld(s_load[CH_MATCH]),
        .cnt(s_cnt), .hit_t(hit_t), .seen(seen)
    );

    stt_snap #(.W(CNT_W), .SYNC_N(SYNC_N)) u_snap (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .s_cnt(s_cnt), .rd_cnt(rd_cnt)
    );

    stt_sync #(.W(2), .STAGES(SYNC_N)) u_stat_sync (
        .clk(clk), .rst_n(rst_n), .d({hit_t, seen}), .q({hit_b, seen_b})
    );

    assign m_evt = hit_b ^ hit_d;
    assign w1c   = wr && (bus_addr == A_CTRL) && bus_wdata[B_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            det_q <= 1'b0;
            hit_d <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (wr && bus_addr == A_CTRL) en_q <= bus_wdata[B_EN];
            det_q <= det_q | seen_b;
            hit_d <= hit_b;
            if (m_evt)    flag <= 1'b1;
            else if (w1c) flag <= 1'b0;
        end
    end

    assign irq = flag;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]                 = en_q;
                bus_rdata[B_DET]                = det_q;
                bus_rdata[B_PEND +: NCHAN]      = busy;
                bus_rdata[B_FLAG]               = flag;
            end
            A_TRIM:  bus_rdata = 32'(hold[CH_TRIM] & TRIM_MASK);
            A_COUNT: bus_rdata = 32'(rd_cnt);
            A_MATCH: bus_rdata = 32'(hold[CH_MATCH]);
        endcase
    end
endmodule

// File: rtl/stt_checker.sv
module stt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        irq,
    input logic        det_q,
    input logic [2:0]  busy,
    input logic [31:0] trim_hold,
    input logic        m_evt
);
    logic wr_ctrl, wr_trim;
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == 2'd0);
    assign wr_trim = bus_sel && bus_wr && (bus_addr == 2'd1);

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[5] && !m_evt) |=> !irq);

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_evt |=> irq);

    assert_detect_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        det_q |=> det_q);

    assert_pend_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy[0]) |-> $past(wr_trim));

    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] && wr_trim) |=> $stable(trim_hold));
endmodule

bind slow_tick_timer stt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
    .det_q(det_q), .busy(busy), .trim_hold(32'(hold[0])), .m_evt(m_evt)
);

// File: tb/slow_tick_timer_bench.sv
module slow_tick_timer_bench;
    logic        clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sclk_run = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0, cyc = 0;
    logic        done = 1'b0;

    slow_tick_timer u_slow_tick_timer (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;
    always begin
        #28;
        if (sclk_run) sclk = ~sclk;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_fail = n_fail + 1;
            n_run  = n_run + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 4000; k++) begin
            bread(2'd0, v);
            if (v[4:2] == 3'b000) return;
        end
        chk("R5 pending never cleared", v[4:2], 3'b000);
    endtask

    task automatic sedges(input int n);
        repeat (n) @(posedge sclk);
    endtask

    logic [31:0] v, c1, c2;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        bread(2'd0, v); chk("R1 ctrl after reset", v, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R9: detect bit appears, then sticks when slow clock stops
        sclk_run = 1'b1;
        sedges(6);
        bread(2'd0, v); chk("R9 detect set", {31'b0, v[1]}, 32'h1);
        sclk_run = 1'b0;
        repeat (60) @(negedge clk);
        bread(2'd0, v); chk("R9 detect sticky while stopped", {31'b0, v[1]}, 32'h1);
        sclk_run = 1'b1;

        // R5, R6, R10: pending bit and ignored write
        bwrite(2'd1, 32'd5);
        bread(2'd0, v); chk("R5 trim pending set", {31'b0, v[2]}, 32'h1);
        bwrite(2'd1, 32'd2);
        wait_idle();
        bread(2'd1, v); chk("R6 busy write ignored", v, 32'd5);
        bwrite(2'd3, 32'hDEAD_BEEF);
        bread(2'd0, v); chk("R5 match pending set", {31'b0, v[4]}, 32'h1);
        wait_idle();
        bread(2'd3, v); chk("R10 match readback", v, 32'hDEAD_BEEF);
        bwrite(2'd1, 32'h0003_0007);
        wait_idle();
        bread(2'd1, v); chk("R10 trim readback masked", v, 32'h0000_0007);

        // R4: count loads, disabled
        for (int i = 0; i < 6; i++) begin
            logic [31:0] pat;
            pat = (32'h1357_9BDF * (i + 1)) ^ (32'hA5A5_0000 >> i);
            bwrite(2'd2, pat);
            bread(2'd0, v); chk("R5 count pending set", {31'b0, v[3]}, 32'h1);
            wait_idle();
            sedges(10);
            bread(2'd2, v); chk("R4 count load readback", v, pat);
        end

        // R2: rate sweep over trim 0..3 with a fixed window of 24 slow edges
        for (int n = 0; n < 4; n++) begin
            int exp_d, d;
            bwrite(2'd0, 32'd0);
            bwrite(2'd1, n);
            wait_idle();
            bwrite(2'd2, 32'd0);
            wait_idle();
            @(posedge sclk);
            bwrite(2'd0, 32'd1);
            sedges(24);
            bwrite(2'd0, 32'd0);
            sedges(12);
            bread(2'd2, c1);
            exp_d = 24 / (n + 1);
            d = int'(c1) - exp_d;
            chk("R2 advance per trim", {31'b0, (d >= -1 && d <= 1)}, 32'h1);
            if (!(d >= -1 && d <= 1)) $display("  trim=%0d count=%0d expected~%0d", n, c1, exp_d);
            sedges(8);
            bread(2'd2, c2);
            chk("R2 holds when disabled", c2, c1);
        end

        // R3: wrap
        bwrite(2'd1, 32'd0);
        wait_idle();
        bwrite(2'd2, 32'hFFFF_FFFE);
        wait_idle();
        @(posedge sclk);
        bwrite(2'd0, 32'd1);
        sedges(5);
        bwrite(2'd0, 32'd0);
        sedges(12);
        bread(2'd2, v);
        chk("R3 wrap to small value", {31'b0, (v >= 32'd2 && v <= 32'd4)}, 32'h1);

        // R7, R8: match interrupt
        bwrite(2'd3, 32'd40);
        wait_idle();
        bwrite(2'd2, 32'd30);
        wait_idle();
        sedges(4);
        bwrite(2'd0, 32'h20);
        repeat (3) @(negedge clk);
        chk("R8 flag cleared by w1c", {31'b0, irq}, 32'h0);
        sedges(20);
        chk("R7 no irq before match", {31'b0, irq}, 32'h0);
        bwrite(2'd0, 32'h1);
        for (int k = 0; k < 4000 && !irq; k++) @(negedge clk);
        chk("R7 irq on match", {31'b0, irq}, 32'h1);
        bread(2'd0, v); chk("R7 flag bit", {31'b0, v[5]}, 32'h1);
        bwrite(2'd0, 32'h0);
        sedges(12);
        bread(2'd2, v);
        chk("R7 count reached match", {31'b0, (v >= 32'd40 && v <= 32'd44)}, 32'h1);
        bwrite(2'd0, 32'h0);
        repeat (3) @(negedge clk);
        chk("R8 writing 0 keeps flag", {31'b0, irq}, 32'h1);
        bwrite(2'd0, 32'h20);
        repeat (3) @(negedge clk);
        chk("R8 w1c clears irq", {31'b0, irq}, 32'h0);
        bread(2'd0, v); chk("R8 flag bit cleared", {31'b0, v[5]}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule